// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 16-bit tri-state buses, A and B, and can move data in either direction. Each direction has its own storage register. The A-side register samples bus A, and the B-side register samples bus B. A driven bus can carry one of two sources: the live value on the opposite bus, or the word held in that direction's register. The word is split into two 8-bit lanes. Every control (capture strobe, source select and drive enable) exists once per lane for each direction, so the two bytes work independently. Tying the lane controls together gives full 16-bit behaviour.

Captures happen in the `clk` domain. A register lane loads its bus lane on the first clock edge that sees its capture strobe high after it was low. Holding the strobe high does not load again. Drive to bus B is enabled active-high. Drive to bus A is enabled active-low. With both drives off, both buses are inputs and both registers can still capture. When one lane drives in both directions at once, both outputs of that lane use stored data whatever the selects say. This keeps a live value from circulating between the buses.

Top module: `xcvr_dual_bus_reg`

## Requirements
- R1: A synchronous active-high reset clears both storage registers to zero.
- R2: For each lane, the A-side register loads that lane of bus A on the first `clk` edge where `cap_ab` for the lane is high and was low at the previous edge. Holding the strobe high does not reload, even if bus A changes.
- R3: For each lane, the B-side register loads that lane of bus B on the first `clk` edge where `cap_ba` for the lane is high and was low at the previous edge. Holding the strobe high does not reload, even if bus B changes.
- R4: With `oe_ab` high and `sel_ab` low (0 = live) in a lane, and bus A not driven by the block in that lane, the bus B lane follows the bus A lane combinationally, with no clock edge needed.
- R5: With `oe_ab` high and `sel_ab` high (1 = stored) in a lane, the bus B lane shows the A-side register lane. It ignores changes on bus A between captures.
- R6: With `oe_ba_n` low in a lane, the bus A lane shows the live bus B lane when `sel_ba` is low, and the B-side register lane when `sel_ba` is high.
- R7: With `oe_ab` low, the block leaves the bus B lane undriven. With `oe_ba_n` high, it leaves the bus A lane undriven.
- R8: Lane 0 covers bits 7:0 and lane 1 covers bits 15:8. Control bit n acts only on lane n, both for capture and for drive.
- R9: Both registers capture while neither bus is driven by the block.
- R10: When a lane drives in both directions (`oe_ab` high and `oe_ba_n` low), bus B shows the A-side register and bus A shows the B-side register, whatever the selects are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_ab | input | 2 | Per-lane capture strobe for the A-side register |
| cap_ba | input | 2 | Per-lane capture strobe for the B-side register |
| sel_ab | input | 2 | Per-lane source for bus B: 0 live A, 1 stored |
| sel_ba | input | 2 | Per-lane source for bus A: 0 live B, 1 stored |
| oe_ab | input | 2 | Per-lane drive enable for bus B, active high |
| oe_ba_n | input | 2 | Per-lane drive enable for bus A, active low |
| a_bus | inout | 16 | Bus A |
| b_bus | inout | 16 | Bus B |

## Verification
The registers have no direct port, so their state can only be seen by switching a direction to stored and enabling its drive. A wrong capture, such as a reload while the strobe is held high or a load into the wrong lane, shows up in full on the opposite bus as soon as stored drive is selected. A broken enable or lane decode shows up straight away. Either an undriven bus carries ones, or a lane that should be quiet follows its neighbour. Live paths are combinational, so they are checked with no clock edge between the stimulus and the sample.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int LANE_W_DEF  = 8;
    localparam int N_LANES_DEF = 2;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic cap;
        logic sel;
        logic drive;
    } dir_ctrl_t;

    function automatic logic cap_edge(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

    function automatic src_sel_e pick_src(input logic sel, input logic both_on);
        return (sel | both_on) ? SRC_STORED : SRC_LIVE;
    endfunction

endpackage

// File: rtl/xcvr_lane_store.sv
module xcvr_lane_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    import xcvr_pkg::*;

    logic cap_q;

    always_ff @(posedge clk) begin
        cap_q <= cap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (cap_edge(cap, cap_q)) begin
            q <= din;
        end
    end
endmodule

// File: rtl/xcvr_lane_drive.sv
module xcvr_lane_drive #(
    parameter int W = 8
) (
    input  xcvr_pkg::dir_ctrl_t ctrl,
    input  logic                both_on,
    input  logic [W-1:0]        live,
    input  logic [W-1:0]        stored,
    output logic [W-1:0]        val,
    output logic                en
);
    import xcvr_pkg::*;

    src_sel_e src;

    always_comb begin
        src = pick_src(ctrl.sel, both_on);
        val = (src == SRC_STORED) ? stored : live;
        en  = ctrl.drive;
    end
endmodule

// File: rtl/xcvr_dual_bus_reg.sv
module xcvr_dual_bus_reg #(
    parameter int LANE_W  = xcvr_pkg::LANE_W_DEF,
    parameter int N_LANES = xcvr_pkg::N_LANES_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_LANES-1:0]          cap_ab,
    input  logic [N_LANES-1:0]          cap_ba,
    input  logic [N_LANES-1:0]          sel_ab,
    input  logic [N_LANES-1:0]          sel_ba,
    input  logic [N_LANES-1:0]          oe_ab,
    input  logic [N_LANES-1:0]          oe_ba_n,
    inout  wire  [LANE_W*N_LANES-1:0]   a_bus,
    inout  wire  [LANE_W*N_LANES-1:0]   b_bus
);
    import xcvr_pkg::*;

    localparam int BUS_W = LANE_W * N_LANES;

    logic [BUS_W-1:0] a_store;
    logic [BUS_W-1:0] b_store;

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        dir_ctrl_t        ab_c;
        dir_ctrl_t        ba_c;
        logic             both_on;
        logic [LANE_W-1:0] b_val;
        logic [LANE_W-1:0] a_val;
        logic             b_en;
        logic             a_en;

        assign ab_c    = '{cap: cap_ab[l], sel: sel_ab[l], drive: oe_ab[l]};
        assign ba_c    = '{cap: cap_ba[l], sel: sel_ba[l], drive: ~oe_ba_n[l]};
        assign both_on = ab_c.drive & ba_c.drive;

        xcvr_lane_store #(.W(LANE_W)) u_store_a (
            .clk (clk),
            .rst (rst),
            .cap (ab_c.cap),
            .din (a_bus[l*LANE_W +: LANE_W]),
            .q   (a_store[l*LANE_W +: LANE_W])
        );

        xcvr_lane_store #(.W(LANE_W)) u_store_b (
            .clk (clk),
            .rst (rst),
            .cap (ba_c.cap),
            .din (b_bus[l*LANE_W +: LANE_W]),
            .q   (b_store[l*LANE_W +: LANE_W])
        );

        xcvr_lane_drive #(.W(LANE_W)) u_drive_b (
            .ctrl    (ab_c),
            .both_on (both_on),
            .live    (a_bus[l*LANE_W +: LANE_W]),
            .stored  (a_store[l*LANE_W +: LANE_W]),
            .val     (b_val),
            .en      (b_en)
        );

        xcvr_lane_drive #(.W(LANE_W)) u_drive_a (
            .ctrl    (ba_c),
            .both_on (both_on),
            .live    (b_bus[l*LANE_W +: LANE_W]),
            .stored  (b_store[l*LANE_W +: LANE_W]),
            .val     (a_val),
            .en      (a_en)
        );

        assign b_bus[l*LANE_W +: LANE_W] = b_en ? b_val : {LANE_W{1'bz}};
        assign a_bus[l*LANE_W +: LANE_W] = a_en ? a_val : {LANE_W{1'bz}};
    end
endmodule

// File: rtl/xcvr_dual_bus_chk.sv
module xcvr_dual_bus_chk #(
    parameter int LANE_W  = 8,
    parameter int N_LANES = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic [N_LANES-1:0]        cap_ab,
    input logic [N_LANES-1:0]        cap_ba,
    input logic [N_LANES-1:0]        sel_ab,
    input logic [N_LANES-1:0]        sel_ba,
    input logic [N_LANES-1:0]        oe_ab,
    input logic [N_LANES-1:0]        oe_ba_n,
    input logic [LANE_W*N_LANES-1:0] a_bus,
    input logic [LANE_W*N_LANES-1:0] b_bus,
    input logic [LANE_W*N_LANES-1:0] a_store,
    input logic [LANE_W*N_LANES-1:0] b_store
);
    // R1: reset empties both registers
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (a_store == '0 && b_store == '0));

    for (genvar l = 0; l < N_LANES; l++) begin : g_chk
        // R2: a rising strobe loads the A lane
        p_cap_a_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(cap_ab[l]) |=> a_store[l*LANE_W +: LANE_W] == $past(a_bus[l*LANE_W +: LANE_W]));
        // R2: without a rising strobe the A lane holds
        p_hold_a_r2: assert property (@(posedge clk) disable iff (rst)
            !$rose(cap_ab[l]) |=> $stable(a_store[l*LANE_W +: LANE_W]));
        // R3: a rising strobe loads the B lane
        p_cap_b_r3: assert property (@(posedge clk) disable iff (rst)
            $rose(cap_ba[l]) |=> b_store[l*LANE_W +: LANE_W] == $past(b_bus[l*LANE_W +: LANE_W]));
        // R5: stored drive toward B shows the A register
        p_stored_b_r5: assert property (@(posedge clk) disable iff (rst)
            (oe_ab[l] && sel_ab[l]) |-> b_bus[l*LANE_W +: LANE_W] == a_store[l*LANE_W +: LANE_W]);
        // R10: both directions on gives stored data on both buses
        p_both_on_r10: assert property (@(posedge clk) disable iff (rst)
            (oe_ab[l] && !oe_ba_n[l]) |->
                (a_bus[l*LANE_W +: LANE_W] == b_store[l*LANE_W +: LANE_W] &&
                 b_bus[l*LANE_W +: LANE_W] == a_store[l*LANE_W +: LANE_W]));
    end
endmodule

bind xcvr_dual_bus_reg xcvr_dual_bus_chk #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cap_ab  (cap_ab),
    .cap_ba  (cap_ba),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .oe_ab   (oe_ab),
    .oe_ba_n (oe_ba_n),
    .a_bus   (a_bus),
    .b_bus   (b_bus),
    .a_store (a_store),
    .b_store (b_store)
);

// File: tb/xcvr_dual_bus_reg_tb.sv
module xcvr_dual_bus_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cap_ab, cap_ba, sel_ab, sel_ba, oe_ab, oe_ba_n;
    logic [15:0] a_tb, b_tb;
    logic        a_tb_on, b_tb_on;
    wire  [15:0] a_bus, b_bus;
    int          n_checks = 0;
    int          n_errors = 0;
    logic [15:0] got;

    always #10 clk = ~clk;

    assign a_bus = a_tb_on ? a_tb : 16'bz;
    assign b_bus = b_tb_on ? b_tb : 16'bz;

    xcvr_dual_bus_reg dut_i (
        .clk     (clk),
        .rst     (rst),
        .cap_ab  (cap_ab),
        .cap_ba  (cap_ba),
        .sel_ab  (sel_ab),
        .sel_ba  (sel_ba),
        .oe_ab   (oe_ab),
        .oe_ba_n (oe_ba_n),
        .a_bus   (a_bus),
        .b_bus   (b_bus)
    );

    function automatic int ones_in(input logic [15:0] v);
        int n = 0;
        for (int i = 0; i < 16; i++) if (v[i] === 1'b1) n++;
        return n;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_quiet(input string req, input logic [15:0] act);
        n_checks++;
        if (ones_in(act) != 0) begin
            n_errors++;
            $display("FAIL %s: undriven bits read %h expected none high", req, act);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        cap_ab = 2'b00; cap_ba = 2'b00; sel_ab = 2'b00; sel_ba = 2'b00;
        oe_ab = 2'b00; oe_ba_n = 2'b11; a_tb_on = 1'b0; b_tb_on = 1'b0;
    endtask

    task automatic load(input logic [15:0] av, input logic [15:0] bv,
                        input logic [1:0] ma, input logic [1:0] mb);
        go_idle();
        a_tb = av; b_tb = bv; a_tb_on = 1'b1; b_tb_on = 1'b1;
        @(negedge clk);
        cap_ab = ma; cap_ba = mb;
        @(negedge clk);
        cap_ab = 2'b00; cap_ba = 2'b00;
        @(negedge clk);
    endtask

    task automatic peek_a_store(output logic [15:0] v);
        go_idle();
        oe_ab = 2'b11; sel_ab = 2'b11;
        #1 v = b_bus;
        go_idle();
    endtask

    task automatic peek_b_store(output logic [15:0] v);
        go_idle();
        oe_ba_n = 2'b00; sel_ba = 2'b11;
        #1 v = a_bus;
        go_idle();
    endtask

    task automatic t_reset();
        a_tb = 16'h0; b_tb = 16'h0;
        go_idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        peek_a_store(got); check("R1 A register after reset", got, 16'h0000);
        peek_b_store(got); check("R1 B register after reset", got, 16'h0000);
    endtask

    task automatic t_isolated();
        load(16'h1234, 16'hABCD, 2'b11, 2'b11);
        peek_a_store(got); check("R2/R9 A capture with buses idle", got, 16'h1234);
        peek_b_store(got); check("R3/R9 B capture with buses idle", got, 16'hABCD);
    endtask

    task automatic t_edge_only();
        go_idle();
        a_tb = 16'h5A5A; b_tb = 16'hC3C3; a_tb_on = 1'b1; b_tb_on = 1'b1;
        @(negedge clk);
        cap_ab = 2'b11; cap_ba = 2'b11;
        @(negedge clk);
        a_tb = 16'hFFFF; b_tb = 16'h0F0F;
        repeat (3) @(negedge clk);
        cap_ab = 2'b00; cap_ba = 2'b00;
        peek_a_store(got); check("R2 held strobe does not reload A", got, 16'h5A5A);
        peek_b_store(got); check("R3 held strobe does not reload B", got, 16'hC3C3);
    endtask

    task automatic t_live();
        go_idle();
        oe_ab = 2'b11; sel_ab = 2'b00; a_tb = 16'h8421; a_tb_on = 1'b1;
        #1 check("R4 live A to B", b_bus, 16'h8421);
        a_tb = 16'h7E18;
        #1 check("R4 live A to B follows without clock", b_bus, 16'h7E18);
        go_idle();
        oe_ba_n = 2'b00; sel_ba = 2'b00; b_tb = 16'h3C96; b_tb_on = 1'b1;
        #1 check("R6 live B to A", a_bus, 16'h3C96);
        b_tb = 16'h0001;
        #1 check("R6 live B to A follows without clock", a_bus, 16'h0001);
        go_idle();
    endtask

    task automatic t_stored();
        go_idle();
        oe_ab = 2'b11; sel_ab = 2'b11; a_tb = 16'h0000; a_tb_on = 1'b1;
        #1 check("R5 stored A drives B", b_bus, 16'h5A5A);
        a_tb = 16'hFFFF;
        #1 check("R5 stored output ignores bus A", b_bus, 16'h5A5A);
        go_idle();
        oe_ba_n = 2'b00; sel_ba = 2'b11; b_tb = 16'h1111; b_tb_on = 1'b1;
        #1 check("R6 stored B drives A", a_bus, 16'hC3C3);
        go_idle();
    endtask

    task automatic t_quiet();
        go_idle();
        sel_ab = 2'b11; sel_ba = 2'b11;
        #1;
        check_quiet("R7 bus B undriven with oe_ab low", b_bus);
        check_quiet("R7 bus A undriven with oe_ba_n high", a_bus);
        go_idle();
    endtask

    task automatic t_lanes();
        load(16'h9911, 16'h0000, 2'b01, 2'b00);
        peek_a_store(got); check("R8 lane 0 strobe loads only bits 7:0", got, 16'h5A11);
        peek_b_store(got); check("R8 unstrobed B register unchanged", got, 16'hC3C3);
        go_idle();
        oe_ab = 2'b01; sel_ab = 2'b01;
        #1 check("R8 lane 0 stored drive", {8'h00, b_bus[7:0]}, 16'h0011);
        check_quiet("R8 lane 1 of bus B undriven", {b_bus[15:8], 8'h00});
        go_idle();
        oe_ab = 2'b10; sel_ab = 2'b00; a_tb = 16'h77FF; a_tb_on = 1'b1;
        #1 check("R8 lane 1 live drive", {b_bus[15:8], 8'h00}, 16'h7700);
        check_quiet("R8 lane 0 of bus B undriven", {8'h00, b_bus[7:0]});
        go_idle();
    endtask

    task automatic t_both();
        go_idle();
        oe_ab = 2'b11; oe_ba_n = 2'b00; sel_ab = 2'b00; sel_ba = 2'b00;
        #1;
        check("R10 both on, live requested, bus B", b_bus, 16'h5A11);
        check("R10 both on, live requested, bus A", a_bus, 16'hC3C3);
        sel_ab = 2'b11; sel_ba = 2'b11;
        #1;
        check("R10 both on, stored, bus B", b_bus, 16'h5A11);
        check("R10 both on, stored, bus A", a_bus, 16'hC3C3);
        go_idle();
    endtask

    initial begin
        rst = 1'b1;
        t_reset();
        t_isolated();
        t_edge_only();
        t_live();
        t_stored();
        t_quiet();
        t_lanes();
        t_both();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule